// File: doc/BRIEF.md
# Event-Selectable Performance Counter Bank

This block holds a small set of wide performance counters for a cache controller. Each counter is pointed at one event source by a configuration write. It then adds that source's contribution on every clock. A source is one of three kinds: the clock itself, a single-bit event flag, or a small occupancy bus whose value (for example, the number of buffers in use) is added whole each cycle.

Software, or a debug agent, configures a counter through a write port. The configuration carries an event code and a clear-on-read enable. A counter is read through a read port that returns the value one cycle later. When a counter has clear-on-read set, the read also restarts it, and the increment from the reading cycle is kept so that no event is lost. Changing a counter's configuration never disturbs its accumulated count.

Top module: `evt_counter_bank`

## Requirements
- R1: After reset every counter holds 0, uses event code 0, has clear-on-read off, and `rdValid` is 0. The four counters (64 bits each) count independently.
- R2: A cycle with `wrEn` high loads counter `wrAddr` with event code `wrData[4:0]` and clear-on-read enable `wrData[5]`. The old code still governs the increment at that clock edge, and the new code governs from the next edge on. The accumulated count is not changed by the write.
- R3: Event code 0 adds 1 to the counter on every clock edge.
- R4: Event codes 1 to 8 add `flagIn[code-1]` (0 or 1) at each clock edge.
- R5: Event codes 9 to 12 add the 3-bit occupancy value `occIn[3*(code-9) +: 3]` (0 to 4 in normal use) at each clock edge.
- R6: Event codes 13 to 31 are undefined and add nothing, whatever the flag and occupancy inputs are.
- R7: A cycle with `rdEn` high reads counter `rdAddr`. At the next edge `rdValid` goes high for one cycle, and `rdData` holds the counter value from just before that edge. With `rdEn` low, `rdValid` is 0 at the next edge.
- R8: A read of a counter with clear-on-read set leaves that counter holding only the increment of the reading cycle. Back-to-back reads therefore return that single increment.
- R9: A read of a counter with clear-on-read off leaves its count running undisturbed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Configuration write strobe |
| wrAddr | input | 2 | Counter selected for configuration |
| wrData | input | 6 | Bit 5 clear-on-read enable, bits 4:0 event code |
| rdEn | input | 1 | Read strobe |
| rdAddr | input | 2 | Counter selected for reading |
| rdData | output | 64 | Value returned by the last read |
| rdValid | output | 1 | High one cycle after a read strobe |
| flagIn | input | 8 | Single-bit event flags |
| occIn | input | 12 | Four 3-bit occupancy buses, bus k at bits 3k+2:3k |

## Verification
The results arrive one edge after their cause. A read strobe's data and valid appear one edge later. An event input sampled at an edge shows up in the count at that same edge, so it is visible to a read strobed at the next edge. A configuration write changes the increment one edge after the write. The bench drives and samples on falling edges. It measures a counter by pairing a clearing read with a second read m cycles later and expects exactly m+1 increments. For non-clearing reads it takes the difference of two reads, and for a configuration change it counts one more edge under the old code.

// File: rtl/evt_counter_pkg.sv
package evt_counter_pkg;
  // Per-counter strobes handed from control to datapath
  typedef struct packed {
    logic cfgLoad;  // load a new event code this edge
    logic rdHit;    // this counter is being read
    logic clrNow;   // restart from this cycle's increment
  } ctrStrobe_t;
endpackage

// File: rtl/evt_counter_ctrl.sv
module evt_counter_ctrl
  import evt_counter_pkg::*;
#(
  parameter int NUM_CTR = 4,
  localparam int IDX_W = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic [IDX_W-1:0]         wrAddr,
  input  logic                     wrCor,
  input  logic                     rdEn,
  input  logic [IDX_W-1:0]         rdAddr,
  output ctrStrobe_t [NUM_CTR-1:0] strobe
);
  logic [NUM_CTR-1:0] corEn;

  always_comb begin
    for (int i = 0; i < NUM_CTR; i++) begin
      strobe[i].cfgLoad = wrEn && (wrAddr == IDX_W'(i));
      strobe[i].rdHit   = rdEn && (rdAddr == IDX_W'(i));
      strobe[i].clrNow  = rdEn && (rdAddr == IDX_W'(i)) && corEn[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      corEn <= '0;
    end else begin
      for (int i = 0; i < NUM_CTR; i++)
        if (wrEn && (wrAddr == IDX_W'(i))) corEn[i] <= wrCor;
    end
  end
endmodule

// File: rtl/evt_counter_dp.sv
module evt_counter_dp
  import evt_counter_pkg::*;
#(
  parameter int NUM_CTR  = 4,
  parameter int CTR_W    = 64,
  parameter int SEL_W    = 5,
  parameter int NUM_FLAG = 8,
  parameter int NUM_OCC  = 4,
  parameter int OCC_W    = 3
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  ctrStrobe_t [NUM_CTR-1:0]          strobe,
  input  logic [SEL_W-1:0]                  wrSel,
  input  logic [NUM_FLAG-1:0]               flagIn,
  input  logic [NUM_OCC*OCC_W-1:0]          occIn,
  output logic [NUM_CTR-1:0][SEL_W-1:0]     evSel,
  output logic [NUM_CTR-1:0][CTR_W-1:0]     ctrVal,
  output logic [CTR_W-1:0]                  rdData,
  output logic                              rdValid
);
  // Amount one counter adds this cycle for a given event code
  function automatic logic [OCC_W-1:0] pickInc(input logic [SEL_W-1:0] code,
                                              input logic [NUM_FLAG-1:0] flags,
                                              input logic [NUM_OCC*OCC_W-1:0] occ);
    logic [OCC_W-1:0] amt;
    amt = '0;
    if (code == '0) amt = OCC_W'(1);
    for (int k = 0; k < NUM_FLAG; k++)
      if (code == SEL_W'(k + 1)) amt = OCC_W'(flags[k]);
    for (int k = 0; k < NUM_OCC; k++)
      if (code == SEL_W'(NUM_FLAG + 1 + k)) amt = occ[k*OCC_W +: OCC_W];
    return amt;
  endfunction

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    logic [SEL_W-1:0] selReg;
    logic [CTR_W-1:0] cnt;
    logic [OCC_W-1:0] incNow;

    assign incNow = pickInc(selReg, flagIn, occIn);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        selReg <= '0;
        cnt    <= '0;
      end else begin
        if (strobe[i].cfgLoad) selReg <= wrSel;
        cnt <= (strobe[i].clrNow ? '0 : cnt) + CTR_W'(incNow);
      end
    end

    assign evSel[i]  = selReg;
    assign ctrVal[i] = cnt;
  end

  logic [CTR_W-1:0] rdMux;
  logic             rdAny;
  always_comb begin
    rdMux = '0;
    rdAny = 1'b0;
    for (int i = 0; i < NUM_CTR; i++) begin
      if (strobe[i].rdHit) rdMux = rdMux | ctrVal[i];
      rdAny = rdAny | strobe[i].rdHit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= rdAny;
      if (rdAny) rdData <= rdMux;
    end
  end
endmodule

// File: rtl/evt_counter_bank.sv
module evt_counter_bank
  import evt_counter_pkg::*;
#(
  parameter int NUM_CTR  = 4,
  parameter int CTR_W    = 64,
  parameter int SEL_W    = 5,
  parameter int NUM_FLAG = 8,
  parameter int NUM_OCC  = 4,
  parameter int OCC_W    = 3,
  localparam int IDX_W   = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic [IDX_W-1:0]         wrAddr,
  input  logic [SEL_W:0]           wrData,
  input  logic                     rdEn,
  input  logic [IDX_W-1:0]         rdAddr,
  output logic [CTR_W-1:0]         rdData,
  output logic                     rdValid,
  input  logic [NUM_FLAG-1:0]      flagIn,
  input  logic [NUM_OCC*OCC_W-1:0] occIn
);
  ctrStrobe_t [NUM_CTR-1:0]      strobe;
  logic [NUM_CTR-1:0][SEL_W-1:0] evSel;
  logic [NUM_CTR-1:0][CTR_W-1:0] ctrVal;

  evt_counter_ctrl #(.NUM_CTR(NUM_CTR)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrCor(wrData[SEL_W]),
    .rdEn(rdEn), .rdAddr(rdAddr),
    .strobe(strobe)
  );

  evt_counter_dp #(
    .NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .SEL_W(SEL_W),
    .NUM_FLAG(NUM_FLAG), .NUM_OCC(NUM_OCC), .OCC_W(OCC_W)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .wrSel(wrData[SEL_W-1:0]),
    .flagIn(flagIn), .occIn(occIn),
    .evSel(evSel), .ctrVal(ctrVal),
    .rdData(rdData), .rdValid(rdValid)
  );
endmodule

// File: rtl/evt_counter_chk.sv
module evt_counter_chk
  import evt_counter_pkg::*;
#(
  parameter int NUM_CTR  = 4,
  parameter int CTR_W    = 64,
  parameter int SEL_W    = 5,
  parameter int NUM_FLAG = 8,
  parameter int NUM_OCC  = 4,
  localparam int IDX_W   = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1,
  localparam int FIRST_UNDEF = NUM_FLAG + NUM_OCC + 1
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          rdEn,
  input logic [IDX_W-1:0]              rdAddr,
  input logic [CTR_W-1:0]              rdData,
  input logic                          rdValid,
  input ctrStrobe_t [NUM_CTR-1:0]      strobe,
  input logic [NUM_CTR-1:0][SEL_W-1:0] evSel,
  input logic [NUM_CTR-1:0][CTR_W-1:0] ctrVal
);
  a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid);
  a_r7_valid_idle: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> !rdValid);
  a_r7_read_value: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdData == $past(ctrVal[rdAddr]));

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_chk
    a_r3_cycle_step: assert property (@(posedge clk) disable iff (!rstN)
      (evSel[i] == '0) && !strobe[i].clrNow |=> ctrVal[i] == $past(ctrVal[i]) + CTR_W'(1));
    a_r4_flag_step: assert property (@(posedge clk) disable iff (!rstN)
      (evSel[i] >= SEL_W'(1)) && (evSel[i] <= SEL_W'(NUM_FLAG)) && !strobe[i].clrNow
      |=> (ctrVal[i] - $past(ctrVal[i])) <= CTR_W'(1));
    a_r6_undef_hold: assert property (@(posedge clk) disable iff (!rstN)
      (evSel[i] >= SEL_W'(FIRST_UNDEF)) && !strobe[i].clrNow |=> $stable(ctrVal[i]));
    a_r8_undef_clear: assert property (@(posedge clk) disable iff (!rstN)
      (evSel[i] >= SEL_W'(FIRST_UNDEF)) && strobe[i].clrNow |=> ctrVal[i] == '0);
  end
endmodule

bind evt_counter_bank evt_counter_chk #(
  .NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .SEL_W(SEL_W),
  .NUM_FLAG(NUM_FLAG), .NUM_OCC(NUM_OCC)
) u_chk (
  .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdAddr(rdAddr),
  .rdData(rdData), .rdValid(rdValid),
  .strobe(strobe), .evSel(evSel), .ctrVal(ctrVal)
);

// File: tb/sim_evt_counter_bank.sv
module sim_evt_counter_bank;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [5:0]  wrData = '0;
  logic        rdEn = 1'b0;
  logic [1:0]  rdAddr = '0;
  logic [63:0] rdData;
  logic        rdValid;
  logic [7:0]  flagIn = '0;
  logic [11:0] occIn = '0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  evt_counter_bank u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .rdValid(rdValid),
    .flagIn(flagIn), .occIn(occIn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc >= WATCHDOG && !done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < %0d", cyc, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // All tasks are entered and left just after a falling edge.
  task automatic cfgWrite(input int idx, input int code, input bit cor);
    wrEn = 1'b1; wrAddr = 2'(idx); wrData = {cor, 5'(code)};
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input int idx, output logic [63:0] val);
    rdEn = 1'b1; rdAddr = 2'(idx);
    @(negedge clk);
    rdEn = 1'b0;
    check("R7 valid after read", 64'(rdValid), 64'd1);
    val = rdData;
  endtask

  // Clearing read, m idle cycles, then a read: returns (m+1) increments
  task automatic measure(input int idx, input int m, output logic [63:0] val);
    logic [63:0] dummy;
    doRead(idx, dummy);
    repeat (m) @(negedge clk);
    doRead(idx, val);
  endtask

  task automatic testReset();
    logic [63:0] v;
    check("R1 rdValid at reset", 64'(rdValid), 64'd0);
    check("R1 rdData at reset", rdData, 64'd0);
    doRead(3, v);                       // read at first edge after reset
    check("R1 counter 3 starts at zero", v, 64'd0);
    doRead(2, v);                       // one edge elapsed, code 0 default
    check("R1 counter 2 default cycle count", v, 64'd1);
    @(negedge clk);
    check("R7 rdValid idle", 64'(rdValid), 64'd0);
  endtask

  task automatic testCycle();
    logic [63:0] v;
    cfgWrite(0, 0, 1'b1);
    measure(0, 9, v);
    check("R3 cycle count over 10 edges", v, 64'd10);
    doRead(0, v);                       // back-to-back after a clearing read
    check("R8 same-cycle increment kept", v, 64'd1);
  endtask

  task automatic testFlag();
    logic [63:0] v;
    cfgWrite(1, 3, 1'b1);               // flagIn[2]
    flagIn = 8'b0000_0100;
    measure(1, 5, v);
    check("R4 selected flag high", v, 64'd6);
    flagIn = 8'b1111_1011;
    measure(1, 5, v);
    check("R4 other flags ignored", v, 64'd0);
    cfgWrite(1, 8, 1'b1);               // flagIn[7]
    flagIn = 8'b1000_0000;
    measure(1, 3, v);
    check("R4 highest flag code", v, 64'd4);
    flagIn = '0;
  endtask

  task automatic testOcc();
    logic [63:0] v;
    cfgWrite(2, 10, 1'b1);              // occupancy bus 1
    occIn = {3'd4, 3'd4, 3'd3, 3'd4};
    measure(2, 4, v);
    check("R5 bus 1 adds 3", v, 64'd15);
    occIn = {3'd0, 3'd0, 3'd4, 3'd0};
    measure(2, 4, v);
    check("R5 bus 1 adds 4", v, 64'd20);
    cfgWrite(2, 12, 1'b1);              // occupancy bus 3
    occIn = {3'd0, 3'd4, 3'd4, 3'd4};
    measure(2, 4, v);
    check("R5 bus 3 at zero", v, 64'd0);
    occIn = {3'd2, 3'd0, 3'd0, 3'd0};
    measure(2, 6, v);
    check("R5 bus 3 adds 2", v, 64'd14);
    occIn = '0;
  endtask

  task automatic testUndef();
    logic [63:0] v;
    cfgWrite(3, 20, 1'b1);
    flagIn = '1; occIn = '1;
    measure(3, 5, v);
    check("R6 code 20 counts nothing", v, 64'd0);
    cfgWrite(3, 13, 1'b1);
    measure(3, 5, v);
    check("R6 code 13 counts nothing", v, 64'd0);
    flagIn = '0; occIn = '0;
  endtask

  task automatic testNoClearAndCfg();
    logic [63:0] a, b, c, d;
    cfgWrite(1, 0, 1'b0);
    doRead(1, a);
    repeat (4) @(negedge clk);
    doRead(1, b);
    check("R9 read does not clear", b - a, 64'd5);
    cfgWrite(1, 20, 1'b0);              // old code counts at the write edge
    doRead(1, c);
    check("R2 write keeps count", c, b + 64'd2);
    repeat (3) @(negedge clk);
    doRead(1, d);
    check("R2 new code takes effect", d, c);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testCycle();
    testFlag();
    testOcc();
    testUndef();
    testNoClearAndCfg();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule